// File: doc/BRIEF.md
# Field CRC Checker for SD Video Error Detection

This block runs two 16-bit CRC accumulators over the 10-bit words of a standard-definition component video stream. One covers the active picture lines of a field and the other covers the full-field line range. At the start of each new field it closes both running values and keeps them as the results of the field that just ended. When the upstream parser reports a received error-detection packet, the block compares the two kept results with the CRC words carried in that packet. A difference raises a sticky error flag.

The active-picture flag and the full-field flag are each shared by both fields. Flags are raised only in SD mode, only for a CRC whose packet valid bit is set, and only when a closed field result is waiting to be compared. A separate select input chooses the 525-line or the 625-line line ranges. Line numbering, horizontal active-window detection, ancillary-data detection and packet parsing all take place upstream.

Top module: `edh_crc_check`

## Requirements
- R1: Each CRC is 16 bits wide with generator x^16+x^12+x^5+1, preset to zero at each field start. A word's 10 bits enter LSB first. For each bit b: fb = b XOR crc[15], crc shifts left one place, and when fb is 1 it is XORed with 16'h1021.
- R2: In 525 mode (std625_i=0) a word enters the AP CRC only on lines 21..262 when field_i=0 and lines 284..524 when field_i=1. It enters the FF CRC only on lines 12..271 (field_i=0) and 275..525 (field_i=1).
- R3: A word enters a CRC only when valid_i=1, act_word_i=1 and anc_i=0. Timing-reference, blanking and ancillary words have no effect.
- R4: In 625 mode (std625_i=1) the AP lines are 24..310 and 336..622, and the FF lines are 8..317 and 321..630, for field_i=0 and field_i=1 respectively.
- R5: A field_start_i pulse stores both accumulators as the closed-field results and presets the accumulators. An edh_valid_i pulse with an AP result that differs from edh_ap_crc_i sets ap_err_o on the following clock edge, and ff_err_o is left unchanged.
- R6: An FF result that differs from edh_ff_crc_i on edh_valid_i sets ff_err_o, and ap_err_o is left unchanged.
- R7: A mismatch in either field sets the same flag.
- R8: When sd_mode_i=0, no flag is set.
- R9: Each closed-field result is compared at most once. An edh_valid_i with no field closed since the previous packet sets no flag, and with no packet no flag is set.
- R10: When edh_ap_ok_i=0 (or edh_ff_ok_i=0), the AP (or FF) comparison is suppressed.
- R11: Flags stay set until clr_i. When clr_i arrives in the same cycle as a new mismatch, the flag stays set. Both flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_mode_i | input | 1 | 1 = SD mode, error reporting enabled |
| std625_i | input | 1 | 0 = 525-line ranges, 1 = 625-line ranges |
| field_i | input | 1 | 0 = field 1, 1 = field 2 |
| line_i | input | 10 | Current line number |
| field_start_i | input | 1 | Pulse: close current field, preset CRCs |
| valid_i | input | 1 | Word strobe |
| act_word_i | input | 1 | Word lies between SAV and EAV |
| anc_i | input | 1 | Word belongs to ancillary data |
| data_i | input | 10 | Video word |
| edh_valid_i | input | 1 | Pulse: packet correctly received |
| edh_ap_ok_i | input | 1 | Packet AP CRC valid bit |
| edh_ff_ok_i | input | 1 | Packet FF CRC valid bit |
| edh_ap_crc_i | input | 16 | Received AP CRC |
| edh_ff_crc_i | input | 16 | Received FF CRC |
| clr_i | input | 1 | Clear both flags |
| ap_err_o | output | 1 | Sticky active-picture CRC error |
| ff_err_o | output | 1 | Sticky full-field CRC error |

## Verification
The assertions check several rules on every cycle. A flag stays set until it is cleared. Clearing without a new mismatch empties the flag. A flag rises only in the cycle after a packet strobe, never in a cycle that follows SD mode being off, and never when the matching valid bit is low. The CRC arithmetic, the line ranges of both standards, the exclusion of non-picture words and the rule that each closed-field result is compared only once depend on whole field sequences. Only the bench's scenarios can show those, using CRCs that the bench computes itself.

// File: rtl/edh_crc_pkg.sv
package edh_crc_pkg;
  localparam int unsigned DATA_W = 10;
  localparam int unsigned CRC_W  = 16;
  localparam logic [CRC_W-1:0] POLY = 16'h1021;

  function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < DATA_W; i++) begin
      fb = d[i] ^ r[CRC_W-1];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/edh_win_gen.sv
module edh_win_gen #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned AP525_F1_LO = 21,  parameter int unsigned AP525_F1_HI = 262,
  parameter int unsigned AP525_F2_LO = 284, parameter int unsigned AP525_F2_HI = 524,
  parameter int unsigned FF525_F1_LO = 12,  parameter int unsigned FF525_F1_HI = 271,
  parameter int unsigned FF525_F2_LO = 275, parameter int unsigned FF525_F2_HI = 525,
  parameter int unsigned AP625_F1_LO = 24,  parameter int unsigned AP625_F1_HI = 310,
  parameter int unsigned AP625_F2_LO = 336, parameter int unsigned AP625_F2_HI = 622,
  parameter int unsigned FF625_F1_LO = 8,   parameter int unsigned FF625_F1_HI = 317,
  parameter int unsigned FF625_F2_LO = 321, parameter int unsigned FF625_F2_HI = 630
) (
  input  logic              std625_i,
  input  logic              field_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              ap_line_o,
  output logic              ff_line_o
);
  logic [LINE_W-1:0] ap_lo, ap_hi, ff_lo, ff_hi;

  always_comb begin
    unique case ({std625_i, field_i})
      2'b00: begin
        ap_lo = LINE_W'(AP525_F1_LO); ap_hi = LINE_W'(AP525_F1_HI);
        ff_lo = LINE_W'(FF525_F1_LO); ff_hi = LINE_W'(FF525_F1_HI);
      end
      2'b01: begin
        ap_lo = LINE_W'(AP525_F2_LO); ap_hi = LINE_W'(AP525_F2_HI);
        ff_lo = LINE_W'(FF525_F2_LO); ff_hi = LINE_W'(FF525_F2_HI);
      end
      2'b10: begin
        ap_lo = LINE_W'(AP625_F1_LO); ap_hi = LINE_W'(AP625_F1_HI);
        ff_lo = LINE_W'(FF625_F1_LO); ff_hi = LINE_W'(FF625_F1_HI);
      end
      default: begin
        ap_lo = LINE_W'(AP625_F2_LO); ap_hi = LINE_W'(AP625_F2_HI);
        ff_lo = LINE_W'(FF625_F2_LO); ff_hi = LINE_W'(FF625_F2_HI);
      end
    endcase
  end

  assign ap_line_o = (line_i >= ap_lo) && (line_i <= ap_hi);
  assign ff_line_o = (line_i >= ff_lo) && (line_i <= ff_hi);
endmodule

// File: rtl/edh_crc_acc.sv
module edh_crc_acc
  import edh_crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              close_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              consume_i,
  output logic [CRC_W-1:0]  res_o,
  output logic              res_vld_o
);
  logic [CRC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      if (close_i) begin
        res_o     <= acc_q;
        res_vld_o <= 1'b1;
        acc_q     <= '0;
      end else begin
        if (en_i) acc_q <= crc_word(acc_q, data_i);
        if (consume_i) res_vld_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/edh_err_flag.sv
module edh_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~clr_i);  // set wins over clear
  end
endmodule

// File: rtl/edh_crc_check.sv
module edh_crc_check
  import edh_crc_pkg::*;
#(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sd_mode_i,
  input  logic              std625_i,
  input  logic              field_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_start_i,
  input  logic              valid_i,
  input  logic              act_word_i,
  input  logic              anc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              edh_valid_i,
  input  logic              edh_ap_ok_i,
  input  logic              edh_ff_ok_i,
  input  logic [CRC_W-1:0]  edh_ap_crc_i,
  input  logic [CRC_W-1:0]  edh_ff_crc_i,
  input  logic              clr_i,
  output logic              ap_err_o,
  output logic              ff_err_o
);
  localparam int unsigned N_CRC = 2;  // 0: active picture, 1: full field

  logic             ap_line, ff_line, word_ok;
  logic [N_CRC-1:0] en, ok, res_vld, set, flag;
  logic [CRC_W-1:0] res [N_CRC];
  logic [CRC_W-1:0] rx  [N_CRC];

  edh_win_gen #(.LINE_W(LINE_W)) u_win (
    .std625_i (std625_i),
    .field_i  (field_i),
    .line_i   (line_i),
    .ap_line_o(ap_line),
    .ff_line_o(ff_line)
  );

  assign word_ok = valid_i & act_word_i & ~anc_i;
  assign en      = {word_ok & ff_line, word_ok & ap_line};
  assign ok      = {edh_ff_ok_i, edh_ap_ok_i};
  assign rx[0]   = edh_ap_crc_i;
  assign rx[1]   = edh_ff_crc_i;

  for (genvar k = 0; k < N_CRC; k++) begin : g_crc
    edh_crc_acc u_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .close_i  (field_start_i),
      .en_i     (en[k]),
      .data_i   (data_i),
      .consume_i(edh_valid_i),
      .res_o    (res[k]),
      .res_vld_o(res_vld[k])
    );

    assign set[k] = edh_valid_i & sd_mode_i & res_vld[k] & ok[k] & (res[k] != rx[k]);

    edh_err_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set[k]),
      .clr_i (clr_i),
      .flag_o(flag[k])
    );
  end

  assign ap_err_o = flag[0];
  assign ff_err_o = flag[1];
endmodule

// File: rtl/edh_crc_check_chk.sv
module edh_crc_check_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sd_mode_i,
  input logic edh_valid_i,
  input logic edh_ap_ok_i,
  input logic edh_ff_ok_i,
  input logic clr_i,
  input logic ap_err_o,
  input logic ff_err_o
);
  a_r11_ap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_err_o && !clr_i |=> ap_err_o);
  a_r11_ff_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ff_err_o && !clr_i |=> ff_err_o);
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !edh_valid_i |=> !ap_err_o && !ff_err_o);
  a_r9_ap_needs_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ap_err_o) |-> $past(edh_valid_i));
  a_r9_ff_needs_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ff_err_o) |-> $past(edh_valid_i));
  a_r8_sd_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_mode_i |=> !$rose(ap_err_o) && !$rose(ff_err_o));
  a_r10_ap_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edh_ap_ok_i && !ap_err_o |=> !ap_err_o);
  a_r10_ff_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edh_ff_ok_i && !ff_err_o |=> !ff_err_o);
endmodule

bind edh_crc_check edh_crc_check_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sd_mode_i  (sd_mode_i),
  .edh_valid_i(edh_valid_i),
  .edh_ap_ok_i(edh_ap_ok_i),
  .edh_ff_ok_i(edh_ff_ok_i),
  .clr_i      (clr_i),
  .ap_err_o   (ap_err_o),
  .ff_err_o   (ff_err_o)
);

// File: tb/tb_edh_crc_check.sv
module tb_edh_crc_check;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sd_mode = 1'b1, std625 = 1'b0, field = 1'b0, field_start = 1'b0;
  logic [9:0] line = '0, data = '0;
  logic valid = 1'b0, act = 1'b0, anc = 1'b0;
  logic edh_valid = 1'b0, ap_ok = 1'b0, ff_ok = 1'b0, clr = 1'b0;
  logic [15:0] ap_rx = '0, ff_rx = '0;
  logic ap_err, ff_err;

  int checks = 0, fails = 0;
  logic [15:0] exp_ap, exp_ff;

  always #(CLK_PERIOD/2) clk = ~clk;

  edh_crc_check dut (
    .clk_i(clk), .rst_ni(rst_n), .sd_mode_i(sd_mode), .std625_i(std625),
    .field_i(field), .line_i(line), .field_start_i(field_start),
    .valid_i(valid), .act_word_i(act), .anc_i(anc), .data_i(data),
    .edh_valid_i(edh_valid), .edh_ap_ok_i(ap_ok), .edh_ff_ok_i(ff_ok),
    .edh_ap_crc_i(ap_rx), .edh_ff_crc_i(ff_rx), .clr_i(clr),
    .ap_err_o(ap_err), .ff_err_o(ff_err)
  );

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [15:0] model_crc(logic [15:0] c, logic [9:0] d);
    for (int i = 0; i < 10; i++) begin
      if (d[i] != c[15]) c = (c << 1) ^ 16'h1021;
      else               c = c << 1;
    end
    return c;
  endfunction

  function automatic bit in_rng(int l, int lo, int hi);
    return l >= lo && l <= hi;
  endfunction

  function automatic bit ap_line(int l);
    if (!std625) return field ? in_rng(l, 284, 524) : in_rng(l, 21, 262);
    return field ? in_rng(l, 336, 622) : in_rng(l, 24, 310);
  endfunction

  function automatic bit ff_line(int l);
    if (!std625) return field ? in_rng(l, 275, 525) : in_rng(l, 12, 271);
    return field ? in_rng(l, 321, 630) : in_rng(l, 8, 317);
  endfunction

  task automatic check(string req, logic act_v, logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act_v, exp_v);
    end
  endtask

  task automatic word(int l, logic [9:0] d, logic a, logic n);
    @(negedge clk);
    line = 10'(l); data = d; act = a; anc = n; valid = 1'b1;
    if (a && !n && ap_line(l)) exp_ap = model_crc(exp_ap, d);
    if (a && !n && ff_line(l)) exp_ff = model_crc(exp_ff, d);
    @(negedge clk);
    valid = 1'b0; act = 1'b0; anc = 1'b0;
  endtask

  task automatic close_field();
    @(negedge clk);
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic open_field(logic f);
    field = f;
    close_field();
    exp_ap = '0; exp_ff = '0;
  endtask

  // Packet strobe; flags are sampled at the negedge after the capturing edge.
  task automatic pkt(logic [15:0] a, logic [15:0] f, logic aok, logic fok, logic c);
    @(negedge clk);
    ap_rx = a; ff_rx = f; ap_ok = aok; ff_ok = fok; edh_valid = 1'b1; clr = c;
    @(negedge clk);
    edh_valid = 1'b0; clr = 1'b0; ap_ok = 1'b0; ff_ok = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // Mixed field: lines inside/outside both ranges, non-active and ancillary words.
  task automatic fill(int seed);
    int lines [8] = '{5, 9, 13, 22, 25, 270, 300, 320};
    foreach (lines[i]) begin
      int l = lines[i] + (field ? (std625 ? 313 : 263) : 0);
      word(l, 10'(seed * 37 + i * 101), 1'b1, 1'b0);
      word(l, 10'(seed + i), 1'b1, 1'b1);
      word(l, 10'(seed * 3 + i), 1'b0, 1'b0);
    end
  endtask

  initial begin
    exp_ap = '0; exp_ff = '0;
    repeat (3) @(negedge clk);
    check("R11 reset ap", ap_err, 1'b0);
    check("R11 reset ff", ff_err, 1'b0);
    rst_n = 1'b1;

    // R1 R2 R3: sweep patterns in both fields, matching CRCs -> no error
    for (int s = 0; s < 8; s++) begin
      open_field(s[0]);
      fill(s);
      close_field();
      pkt(exp_ap, exp_ff, 1'b1, 1'b1, 1'b0);
      check("R1 R2 R3 match ap", ap_err, 1'b0);
      check("R1 R2 R3 match ff", ff_err, 1'b0);
    end

    // R5 R7: AP mismatch in field 2
    open_field(1'b1); fill(11); close_field();
    pkt(exp_ap ^ 16'h0001, exp_ff, 1'b1, 1'b1, 1'b0);
    check("R5 R7 ap set", ap_err, 1'b1);
    check("R5 ff untouched", ff_err, 1'b0);
    repeat (4) @(negedge clk);
    check("R11 sticky", ap_err, 1'b1);
    clear();
    check("R11 cleared", ap_err, 1'b0);

    // R6 R7: FF mismatch in field 1
    open_field(1'b0); fill(12); close_field();
    pkt(exp_ap, exp_ff ^ 16'h8000, 1'b1, 1'b1, 1'b0);
    check("R6 R7 ff set", ff_err, 1'b1);
    check("R6 ap untouched", ap_err, 1'b0);
    clear();

    // R8: HD mode suppresses
    open_field(1'b0); fill(13); close_field();
    sd_mode = 1'b0;
    pkt(~exp_ap, ~exp_ff, 1'b1, 1'b1, 1'b0);
    check("R8 ap", ap_err, 1'b0);
    check("R8 ff", ff_err, 1'b0);
    sd_mode = 1'b1;

    // R10: per-CRC valid bits
    open_field(1'b1); fill(14); close_field();
    pkt(~exp_ap, ~exp_ff, 1'b0, 1'b1, 1'b0);
    check("R10 ap suppressed", ap_err, 1'b0);
    check("R10 ff compared", ff_err, 1'b1);
    clear();
    open_field(1'b1); fill(15); close_field();
    pkt(~exp_ap, ~exp_ff, 1'b1, 1'b0, 1'b0);
    check("R10 ff suppressed", ff_err, 1'b0);
    check("R10 ap compared", ap_err, 1'b1);
    clear();

    // R9: second packet without a new closed field
    pkt(~exp_ap, ~exp_ff, 1'b1, 1'b1, 1'b0);
    check("R9 ap no result", ap_err, 1'b0);
    check("R9 ff no result", ff_err, 1'b0);
    // R9: no packet at all
    open_field(1'b0); fill(16); close_field();
    repeat (5) @(negedge clk);
    check("R9 no packet", ap_err | ff_err, 1'b0);

    // R4: 625 ranges, field 1 and field 2
    std625 = 1'b1;
    for (int f = 0; f < 2; f++) begin
      open_field(f[0]); fill(20 + f); close_field();
      pkt(exp_ap, exp_ff, 1'b1, 1'b1, 1'b0);
      check("R4 625 ap match", ap_err, 1'b0);
      check("R4 625 ff match", ff_err, 1'b0);
    end
    std625 = 1'b0;

    // R11: clear in the same cycle as a mismatch keeps the flag
    open_field(1'b0); fill(30); close_field();
    pkt(exp_ap ^ 16'h0100, exp_ff, 1'b1, 1'b1, 1'b1);
    check("R11 set beats clear", ap_err, 1'b1);
    clear();
    check("R11 clear after", ap_err, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule